// File: doc/BRIEF.md
# Clock Crossbar Channel Bank

This block is a bank of output clock channels that share one register file. Each channel picks one source out of a set of up to 64 source clocks. It passes that source through a gated 10-bit pre-divider and then a gated 6-bit final divider.

Sources are modelled as single-cycle enable strobes in one system clock domain. Each channel therefore produces two outputs:
- a divided enable strobe;
- a square wave that toggles on every strobe.

Software programs the bank through a byte-addressed, word-wide write/read port. Two command vectors act on the gates: one turns a channel on, the other turns it off. Turning a channel off affects only the final stage, so the front of the chain keeps counting.

Top module: `clkx_bank`

## Requirements
- R1: The select field (bits 5:0 of a channel's byte lane) routes `src_tick[sel]` into the channel. A select value of N_SRC or more routes a constant zero, so the channel emits no strobes.
- R2: Byte addresses decide where each channel's fields live, and the low two address bits are ignored.
  - Routing word: channel k sits in the word at 0x18 + 4*(k/4), in byte lane k%4. The lane holds the select in bits 5:0 and the pre-gate in bit 6.
  - Pre-divider word: channel k's pre ratio field is bits 9:0 of the word at 0x58 + 4*k.
  - Final word: channel k's final ratio field is bits 5:0 and its final gate is bit 6, in the word at 0x164 + 4*k.
- R3: After reset every register reads zero. A read returns the last written field values, with unimplemented bits and unmapped addresses reading zero. Read data appears one cycle after the address.
- R4: Each divider ratio is its field value plus one, so a field of 0 passes strobes through. A source that strobes every S cycles gives an output strobe period of S*(P+1)*(F+1) cycles. This holds whether the division sits in the final divider or in the pre-divider.
- R5: `out_clk` toggles exactly on each output strobe. Its high and low phases are therefore each one strobe period long, which is a 50% duty cycle.
- R6: Command inputs act on the gates as follows.
  - An enable pulse sets both the pre-gate and the final gate.
  - A disable pulse clears only the final gate. The select, pre-gate and ratios stay as they are, and the pre-divider keeps running.
  - If both pulses arrive for a channel in the same cycle, disable wins.
- R7: `ch_active[k]` equals channel k's final gate bit.
- R8: A cleared gate stops its stage's strobes and holds its counter at zero. Take a channel with both gates off and a source that strobes every cycle: after an enable pulse, its first `out_tick` is seen exactly (P+1)*(F+1) clock edges after the enable edge.
- R9: A new ratio takes effect only at the divider's next terminal count. The period already in progress completes with the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | N_SRC | Source clock enable strobes |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Read data, registered |
| ch_enable | input | N_OUT | Per-channel enable pulse (sets both gates) |
| ch_disable | input | N_OUT | Per-channel disable pulse (clears final gate) |
| ch_active | output | N_OUT | Final gate state per channel |
| out_tick | output | N_OUT | Divided output strobe per channel |
| out_clk | output | N_OUT | Square-wave output per channel |

## Verification
Timing of each result:
- A write or command changes the stored fields and `ch_active` at the edge that samples it.
- Read data is due one edge after the read address is presented.
- `out_tick` rises one edge after the final divider reaches its terminal count. From a fully gated state, the first strobe therefore lands exactly (P+1)*(F+1) edges after the enable edge when the source strobes every cycle.

The bench drives inputs and samples outputs on falling edges and counts rising edges between events. Every period, latency and duty check therefore compares against an exact integer number of edges, with no tolerance window.

// File: rtl/clkx_pkg.sv
package clkx_pkg;
   localparam int unsigned SEL_W     = 6;
   localparam int unsigned PRE_W     = 10;
   localparam int unsigned FIN_W     = 6;
   localparam int unsigned LANE_W    = 8;
   localparam int unsigned PGATE_BIT = 6;
   localparam int unsigned FGATE_BIT = 6;

   typedef struct packed {
      logic [SEL_W-1:0] sel;
      logic             pgate;
      logic [PRE_W-1:0] pre;
      logic             fgate;
      logic [FIN_W-1:0] fin;
   } ch_cfg_t;
endpackage

// File: rtl/clkx_tick_div.sv
module clkx_tick_div #(
   parameter int unsigned W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_tick,
   input  logic         gate,
   input  logic [W-1:0] ratio,
   output logic         out_tick
);
   logic [W-1:0] cnt_q;
   logic [W-1:0] act_q;
   logic         term;

   assign term     = (cnt_q == act_q);
   assign out_tick = in_tick & gate & term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= '0;
      end else if (!gate) begin
         cnt_q <= '0;
         act_q <= ratio;
      end else if (in_tick) begin
         if (term) begin
            cnt_q <= '0;
            act_q <= ratio;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/clkx_regs.sv
module clkx_regs
   import clkx_pkg::*;
#(
   parameter int unsigned N_OUT    = 4,
   parameter int unsigned ADDR_W   = 10,
   parameter int unsigned XBAR_OFS = 32'h18,
   parameter int unsigned PRE_OFS  = 32'h58,
   parameter int unsigned FIN_OFS  = 32'h164,
   parameter bit          READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   input  logic [N_OUT-1:0]  ch_enable,
   input  logic [N_OUT-1:0]  ch_disable,
   output ch_cfg_t           cfg [N_OUT]
);
   localparam int unsigned WA_W = ADDR_W - 2;

   logic [WA_W-1:0] wr_word;
   logic [WA_W-1:0] rd_word;
   logic [31:0]     rd_next;
   logic            unused_bits;

   assign wr_word     = wr_addr[ADDR_W-1:2];
   assign rd_word     = rd_addr[ADDR_W-1:2];
   assign unused_bits = ^{wr_addr[1:0], rd_addr[1:0], wr_data};

   for (genvar c = 0; c < N_OUT; c++) begin : g_ch
      localparam int unsigned       LANE   = c % 4;
      localparam logic [WA_W-1:0]   X_WORD = WA_W'((XBAR_OFS / 4) + c / 4);
      localparam logic [WA_W-1:0]   P_WORD = WA_W'((PRE_OFS / 4) + c);
      localparam logic [WA_W-1:0]   F_WORD = WA_W'((FIN_OFS / 4) + c);

      ch_cfg_t q;
      logic    hit_x, hit_p, hit_f;

      assign hit_x = wr_en && (wr_word == X_WORD);
      assign hit_p = wr_en && (wr_word == P_WORD);
      assign hit_f = wr_en && (wr_word == F_WORD);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else begin
            if (hit_x) begin
               q.sel   <= wr_data[LANE*LANE_W +: SEL_W];
               q.pgate <= wr_data[LANE*LANE_W + PGATE_BIT];
            end
            if (hit_p) q.pre <= wr_data[PRE_W-1:0];
            if (hit_f) begin
               q.fin   <= wr_data[FIN_W-1:0];
               q.fgate <= wr_data[FGATE_BIT];
            end
            if (ch_enable[c]) begin
               q.pgate <= 1'b1;
               q.fgate <= 1'b1;
            end
            if (ch_disable[c]) q.fgate <= 1'b0;
         end
      end

      assign cfg[c] = q;
   end

   always_comb begin
      rd_next = '0;
      for (int c = 0; c < N_OUT; c++) begin
         if (int'(rd_word) == int'(XBAR_OFS / 4) + c / 4)
            rd_next[(c % 4)*LANE_W +: SEL_W+1] = {cfg[c].pgate, cfg[c].sel};
         if (int'(rd_word) == int'(PRE_OFS / 4) + c)
            rd_next[PRE_W-1:0] = cfg[c].pre;
         if (int'(rd_word) == int'(FIN_OFS / 4) + c)
            rd_next[FIN_W:0] = {cfg[c].fgate, cfg[c].fin};
      end
   end

   if (READ_REG) begin : g_rd_reg
      logic [31:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_next;
      end
      assign rd_data = rd_q;
   end else begin : g_rd_comb
      assign rd_data = rd_next;
   end
endmodule

// File: rtl/clkx_channel.sv
module clkx_channel
   import clkx_pkg::*;
#(
   parameter int unsigned N_SRC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_tick,
   input  ch_cfg_t          cfg,
   output logic             tick_o,
   output logic             clk_o
);
   logic picked;
   logic pre_tick;
   logic fin_tick;
   logic tick_q;
   logic sq_q;

   always_comb begin
      picked = 1'b0;
      for (int s = 0; s < N_SRC; s++) begin
         if (cfg.sel == SEL_W'(s)) picked = src_tick[s];
      end
   end

   clkx_tick_div #(.W(PRE_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_tick  (picked),
      .gate     (cfg.pgate),
      .ratio    (cfg.pre),
      .out_tick (pre_tick)
   );

   clkx_tick_div #(.W(FIN_W)) u_fin (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_tick  (pre_tick),
      .gate     (cfg.fgate),
      .ratio    (cfg.fin),
      .out_tick (fin_tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q <= 1'b0;
         sq_q   <= 1'b0;
      end else begin
         tick_q <= fin_tick;
         if (fin_tick) sq_q <= ~sq_q;
      end
   end

   assign tick_o = tick_q;
   assign clk_o  = sq_q;
endmodule

// File: rtl/clkx_bank.sv
module clkx_bank
   import clkx_pkg::*;
#(
   parameter int unsigned N_OUT    = 4,
   parameter int unsigned N_SRC    = 8,
   parameter int unsigned ADDR_W   = 10,
   parameter int unsigned XBAR_OFS = 32'h18,
   parameter int unsigned PRE_OFS  = 32'h58,
   parameter int unsigned FIN_OFS  = 32'h164,
   parameter bit          READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   input  logic [N_OUT-1:0]  ch_enable,
   input  logic [N_OUT-1:0]  ch_disable,
   output logic [N_OUT-1:0]  ch_active,
   output logic [N_OUT-1:0]  out_tick,
   output logic [N_OUT-1:0]  out_clk
);
   localparam int unsigned XBAR_WORDS = (N_OUT + 3) / 4;

   if (N_SRC < 1 || N_SRC > 64) begin : g_bad_src
      $error("N_SRC must lie in 1..64");
   end
   if (N_OUT < 1) begin : g_bad_out
      $error("N_OUT must be at least 1");
   end
   if ((XBAR_OFS % 4) != 0 || (PRE_OFS % 4) != 0 || (FIN_OFS % 4) != 0) begin : g_bad_align
      $error("register offsets must be word aligned");
   end
   if (XBAR_OFS + 4*XBAR_WORDS > PRE_OFS) begin : g_bad_xbar
      $error("routing words overlap pre-divider words");
   end
   if (PRE_OFS + 4*N_OUT > FIN_OFS) begin : g_bad_pre
      $error("pre-divider words overlap final words");
   end
   if (FIN_OFS + 4*N_OUT > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   ch_cfg_t cfg [N_OUT];

   clkx_regs #(
      .N_OUT    (N_OUT),
      .ADDR_W   (ADDR_W),
      .XBAR_OFS (XBAR_OFS),
      .PRE_OFS  (PRE_OFS),
      .FIN_OFS  (FIN_OFS),
      .READ_REG (READ_REG)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .ch_enable  (ch_enable),
      .ch_disable (ch_disable),
      .cfg        (cfg)
   );

   for (genvar c = 0; c < N_OUT; c++) begin : g_chan
      clkx_channel #(.N_SRC(N_SRC)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .src_tick (src_tick),
         .cfg      (cfg[c]),
         .tick_o   (out_tick[c]),
         .clk_o    (out_clk[c])
      );
      assign ch_active[c] = cfg[c].fgate;
   end
endmodule

// File: rtl/clkx_bank_chk.sv
module clkx_bank_chk #(
   parameter int unsigned N_OUT = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [N_OUT-1:0] ch_enable,
   input logic [N_OUT-1:0] ch_disable,
   input logic [N_OUT-1:0] ch_active,
   input logic [N_OUT-1:0] out_tick,
   input logic [N_OUT-1:0] out_clk
);
   for (genvar c = 0; c < N_OUT; c++) begin : g_chk
      // R8: a strobe can only leave a channel whose final gate was open
      a_r8_no_tick_when_gated: assert property (@(posedge clk) disable iff (!rst_n)
         out_tick[c] |-> $past(ch_active[c]));

      // R6: disable pulse always closes the final gate
      a_r6_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
         ch_disable[c] |=> !ch_active[c]);

      // R6: lone enable pulse opens the final gate
      a_r6_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_enable[c] && !ch_disable[c]) |=> ch_active[c]);

      // R7: active flag moves only through writes or commands
      a_r7_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (!wr_en && !ch_enable[c] && !ch_disable[c]) |=> $stable(ch_active[c]));

      // R5: square wave changes level only together with a strobe
      a_r5_sq_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
         (out_clk[c] != $past(out_clk[c])) |-> out_tick[c]);
   end
endmodule

bind clkx_bank clkx_bank_chk #(.N_OUT(N_OUT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .ch_enable  (ch_enable),
   .ch_disable (ch_disable),
   .ch_active  (ch_active),
   .out_tick   (out_tick),
   .out_clk    (out_clk)
);

// File: tb/clkx_bank_tb_top.sv
module clkx_bank_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N_OUT  = 4;
   localparam int N_SRC  = 8;
   localparam int ADDR_W = 10;
   localparam logic [9:0] XO = 10'h018;
   localparam logic [9:0] PO = 10'h058;
   localparam logic [9:0] FO = 10'h164;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [N_SRC-1:0]  src_tick = '0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [31:0]       wr_data = '0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [31:0]       rd_data;
   logic [N_OUT-1:0]  ch_enable = '0;
   logic [N_OUT-1:0]  ch_disable = '0;
   logic [N_OUT-1:0]  ch_active;
   logic [N_OUT-1:0]  out_tick;
   logic [N_OUT-1:0]  out_clk;

   int          checks = 0;
   int          errors = 0;
   logic [31:0] xsh = '0;

   clkx_bank dut_i (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .ch_enable(ch_enable), .ch_disable(ch_disable),
      .ch_active(ch_active), .out_tick(out_tick), .out_clk(out_clk)
   );

   initial forever #(CLK_PERIOD/2) clk = ~clk;

   // source i strobes once every i+1 cycles
   initial begin
      int cnt [N_SRC];
      for (int i = 0; i < N_SRC; i++) cnt[i] = 0;
      forever begin
         @(negedge clk);
         for (int i = 0; i < N_SRC; i++) begin
            src_tick[i] = (cnt[i] == i);
            cnt[i] = (cnt[i] == i) ? 0 : cnt[i] + 1;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      wr_addr = a; wr_data = d; wr_en = 1'b1;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [9:0] a, output logic [31:0] d);
      rd_addr = a;
      @(posedge clk); @(negedge clk);
      d = rd_data;
   endtask

   task automatic cmd(input int c, input bit en, input bit dis);
      ch_enable[c] = en; ch_disable[c] = dis;
      @(posedge clk); @(negedge clk);
      ch_enable[c] = 1'b0; ch_disable[c] = 1'b0;
   endtask

   task automatic wait_tick(input int c, input int limit, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < limit; i++) begin
         if (out_tick[c]) begin seen = 1'b1; break; end
         @(posedge clk); @(negedge clk);
      end
   endtask

   task automatic count_ticks(input int c, input int cyc, output int n);
      n = 0;
      for (int i = 0; i < cyc; i++) begin
         @(posedge clk); @(negedge clk);
         if (out_tick[c]) n++;
      end
   endtask

   // edges from one strobe to the next, with the level held in between
   task automatic interval(input int c, input int limit, output int n, output bit duty_ok);
      logic lvl;
      lvl = out_clk[c]; n = 0; duty_ok = 1'b1;
      while (n < limit) begin
         @(posedge clk); n++; @(negedge clk);
         if (out_tick[c]) break;
         if (out_clk[c] != lvl) duty_ok = 1'b0;
      end
      if (out_clk[c] == lvl) duty_ok = 1'b0;
   endtask

   task automatic run_case(input int c, input int sel, input int pf, input int ff);
      int exp, n;
      bit seen, dok;
      exp = (sel + 1) * (pf + 1) * (ff + 1);
      wr(FO + 10'(4*c), 32'(ff));
      wr(PO + 10'(4*c), 32'(pf));
      xsh[8*c +: 8] = 8'(sel);
      wr(XO, xsh);
      cmd(c, 1'b1, 1'b0);
      xsh[8*c + 6] = 1'b1;
      wait_tick(c, 3*exp + 10, seen);
      chk(seen, "R1 R2 strobe from selected source", longint'(seen), 1);
      interval(c, 3*exp + 10, n, dok);
      chk(n == exp, "R4 period", n, exp);
      chk(dok, "R5 duty", longint'(dok), 1);
   endtask

   initial begin
      logic [31:0] d;
      int n;
      bit seen, dok;
      int pcomb [5] = '{0, 0, 3, 0, 64};
      int fcomb [5] = '{0, 5, 2, 63, 0};

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 reset state, R7 inactive after reset
      rd(XO, d); chk(d == 0, "R3 reset routing word", d, 0);
      for (int c = 0; c < N_OUT; c++) begin
         rd(PO + 10'(4*c), d); chk(d == 0, "R3 reset pre word", d, 0);
         rd(FO + 10'(4*c), d); chk(d == 0, "R3 reset final word", d, 0);
      end
      chk(ch_active == 0, "R7 reset active", ch_active, 0);
      chk(out_tick == 0 && out_clk == 0, "R5 reset outputs", {out_tick, out_clk}, 0);

      // R3 readback masks, R2 field positions
      wr(XO, 32'hFFFF_FFFF);
      rd(XO, d); chk(d == 32'h7F7F_7F7F, "R3 routing readback", d, 32'h7F7F_7F7F);
      wr(PO + 10'd4, 32'hFFFF_FFFF);
      rd(PO + 10'd4, d); chk(d == 32'h3FF, "R3 pre readback", d, 32'h3FF);
      wr(FO + 10'd8, 32'hFFFF_FFFF);
      rd(FO + 10'd8, d); chk(d == 32'h7F, "R3 final readback", d, 32'h7F);
      chk(ch_active == 4'b0100, "R7 active follows final gate", ch_active, 4'b0100);
      wr(10'h100, 32'hFFFF_FFFF);
      rd(10'h100, d); chk(d == 0, "R3 unmapped read", d, 0);

      // R1 select 63 is out of range: no strobes despite both gates open
      count_ticks(2, 100, n);
      chk(n == 0, "R1 out-of-range select", n, 0);

      wr(XO, 32'h0); wr(PO + 10'd4, 32'h0); wr(FO + 10'd8, 32'h0);
      chk(ch_active == 0, "R7 final gate cleared by write", ch_active, 0);
      xsh = '0;

      // R1 R2 R4 R5 sweep: every source, several splits
      for (int s = 0; s < N_SRC; s++)
         for (int k = 0; k < 5; k++)
            run_case(s % N_OUT, s, pcomb[k], fcomb[k]);
      run_case(0, 0, 1023, 0);
      run_case(1, 0, 100, 1);

      // R8 counters held while gated, first strobe latency
      wr(FO + 10'd12, 32'h3);
      wr(PO + 10'd12, 32'h2);
      xsh[31:24] = 8'h00;
      wr(XO, xsh);
      count_ticks(3, 40, n);
      chk(n == 0, "R8 no strobes while gated", n, 0);
      cmd(3, 1'b1, 1'b0);
      xsh[30] = 1'b1;
      n = 0;
      while (n < 100) begin
         @(posedge clk); n++; @(negedge clk);
         if (out_tick[3]) break;
      end
      chk(n == 12, "R8 first strobe after enable", n, 12);

      // R6 enable sets both gates
      rd(XO, d); chk(d[31:24] == 8'h40, "R6 enable sets pre gate", d[31:24], 8'h40);
      rd(FO + 10'd12, d); chk(d == 32'h43, "R6 enable sets final gate", d, 32'h43);

      // R6 disable touches only the final gate
      cmd(3, 1'b0, 1'b1);
      chk(ch_active[3] == 1'b0, "R7 inactive after disable", ch_active[3], 0);
      rd(FO + 10'd12, d); chk(d == 32'h03, "R6 final ratio kept", d, 32'h03);
      rd(XO, d); chk(d[31:24] == 8'h40, "R6 pre gate kept", d[31:24], 8'h40);
      rd(PO + 10'd12, d); chk(d == 32'h2, "R6 pre ratio kept", d, 2);
      count_ticks(3, 60, n);
      chk(n == 0, "R8 no strobes after disable", n, 0);
      wr(FO + 10'd12, 32'h43);
      wait_tick(3, 60, seen);
      interval(3, 60, n, dok);
      chk(n == 12, "R6 resumes via final gate only", n, 12);

      // R9 ratio change waits for terminal count
      wr(PO + 10'd12, 32'h0);
      wait_tick(3, 60, seen);
      interval(3, 60, n, dok);
      interval(3, 60, n, dok);
      chk(n == 4, "R9 settled period", n, 4);
      wr_addr = FO + 10'd12; wr_data = 32'h47; wr_en = 1'b1;
      n = 0;
      while (n < 60) begin
         @(posedge clk); n++; @(negedge clk);
         wr_en = 1'b0;
         if (out_tick[3]) break;
      end
      chk(n == 4, "R9 current period keeps old ratio", n, 4);
      interval(3, 60, n, dok);
      chk(n == 8, "R9 new ratio after terminal", n, 8);

      // R6 disable wins over enable
      cmd(3, 1'b1, 1'b1);
      chk(ch_active[3] == 1'b0, "R6 disable wins", ch_active[3], 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule